// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Requests

This block holds the status flags of a byte-oriented synchronous serial port and turns them into interrupt requests. The shifter, the serial clock generator and the bus-conflict detector sit outside it. They report their events as single-cycle strobes: a byte has been received, the shifter has taken the transmit byte, a byte has finished shifting out, and a conflict has been detected. The block also holds the receive and transmit data registers, because the flags follow accesses to those registers.

Software reaches the block through a simple register bus with four word addresses. A flag can only be cleared by software in two steps: a status read must first return the flag as 1, and a later write must then put 0 in that bit position. An overrun keeps the byte already held and freezes the port, raising `xfer_hold_o`, until software clears the overrun flag.

Top module: `ssf_status_top`

## Requirements
- R1: After reset the status register (address 0) reads 0x04, the control register (address 1) reads 0x00, and all interrupt outputs and `xfer_hold_o` are 0. Status bits 7, 5 and 4 always read 0.
- R2: Status bit 1 (receive full) sets on an accepted `rx_done_i`, and the same edge loads `rx_byte_i` into the receive data register (address 2). A read of address 2 returns that byte and clears bit 1.
- R3: When `rx_done_i` arrives while bit 1 is 1 and no overrun is pending, status bit 6 (overrun) sets. The receive data register keeps its old byte and the new byte is dropped.
- R4: While bit 6 is 1, `xfer_hold_o` is 1. An `rx_done_i` then changes neither a flag nor the receive data, and a `tx_load_i` does not set bit 2.
- R5: A status write clears a flag only where it writes 0 and only when the flag is armed. A flag is armed by a status read that returned it as 1. Any status write disarms every flag, and a flag that drops to 0 is disarmed.
- R6: Writing 1 to a status bit never sets it.
- R7: When a set event and an armed write of 0 hit the same flag in the same cycle, the flag stays 1.
- R8: A write to address 3 stores the byte on `tx_data_o` and clears bit 2 (transmit empty) and bit 3 (transmit end). `tx_load_i` sets bit 2. `tx_done_i` sets bit 3 only while bit 2 is 1.
- R9: `conf_err_i` sets status bit 0 (conflict). No hardware event clears it.
- R10: Control bit 2 gates bit 2 onto `irq_tx_o`. Control bit 1 gates bit 1 onto `irq_rx_o` and bit 6 onto `irq_ovr_o`. Control bit 0 gates bit 0 onto `irq_conf_o`. Control bits [2:0] read back at address 1 and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 status, 1 control, 2 receive data, 3 transmit data |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational, 0 when not reading |
| rx_done_i | input | 1 | Strobe: a received byte is complete |
| rx_byte_i | input | DATA_W | Byte that arrives with `rx_done_i` |
| tx_load_i | input | 1 | Strobe: the shifter took the transmit byte |
| tx_done_i | input | 1 | Strobe: the last bit of a byte has shifted out |
| conf_err_i | input | 1 | Strobe: a conflict was detected |
| tx_data_o | output | DATA_W | Transmit data register |
| xfer_hold_o | output | 1 | Tells the shifter to start no transfer (overrun pending) |
| irq_tx_o | output | 1 | Transmit-empty request |
| irq_rx_o | output | 1 | Receive-full request |
| irq_ovr_o | output | 1 | Overrun request |
| irq_conf_o | output | 1 | Conflict request |

## Verification
The case that needs care is a hardware set event landing on a flag in the same cycle as software's armed write of 0 to that flag. The bench first arms the conflict flag with a status read. It then drives `conf_err_i` in the very cycle that writes 0 to bit 0, and expects the flag to read back as 1. A second pair that can coincide is a receive strobe and a read of the receive data while the receive-full flag is set. The bench keeps these two apart: each test that involves an overrun checks where the stored byte ends up, and checks that the overrun flag is set, before it reads the receive data.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_CTRL = 2'd1,
    A_RXD  = 2'd2,
    A_TXD  = 2'd3
  } ssf_addr_e;

  localparam int NFLAG   = 5;
  localparam int FL_CE   = 0;
  localparam int FL_RDRF = 1;
  localparam int FL_TDRE = 2;
  localparam int FL_TEND = 3;
  localparam int FL_ORER = 4;
  localparam int STAT_W  = 8;
  localparam int EN_W    = 3;

  // flag index -> status bit position
  function automatic int stat_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 3;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/ssf_flag.sv
module ssf_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hclr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q_q, armed_q, sw_clr;

  assign sw_clr = wr_i & ~wbit_i & armed_q;
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      // set wins over any clear
      if (set_i)                q_q <= 1'b1;
      else if (hclr_i | sw_clr) q_q <= 1'b0;
      if (wr_i)                 armed_q <= 1'b0;
      else if (rd_i && q_q)     armed_q <= 1'b1;
      else if (!q_q)            armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ssf_data.sv
module ssf_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdr_o,
  output logic [DATA_W-1:0] tdr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_o <= '0;
      tdr_o <= '0;
    end else begin
      if (rx_load_i) rdr_o <= rx_byte_i;
      if (tx_wr_i)   tdr_o <= wdata_i;
    end
  end
endmodule

// File: rtl/ssf_irq.sv
module ssf_irq
  import ssf_pkg::*;
#(
  parameter int EN_BITS = EN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [EN_BITS-1:0] wdata_i,
  input  logic [NFLAG-1:0]   flag_i,
  output logic [EN_BITS-1:0] en_o,
  output logic               irq_tx_o,
  output logic               irq_rx_o,
  output logic               irq_ovr_o,
  output logic               irq_conf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= wdata_i;
  end

  assign irq_tx_o   = en_o[2] & flag_i[FL_TDRE];
  assign irq_rx_o   = en_o[1] & flag_i[FL_RDRF];
  assign irq_ovr_o  = en_o[1] & flag_i[FL_ORER];
  assign irq_conf_o = en_o[0] & flag_i[FL_CE];
endmodule

// File: rtl/ssf_status_top.sv
module ssf_status_top
  import ssf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  input  logic              conf_err_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              xfer_hold_o,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_ovr_o,
  output logic              irq_conf_o
);
  logic              stat_rd, stat_wr, ctrl_wr, rxd_rd, txd_wr;
  logic              rx_acc, rx_load;
  logic [NFLAG-1:0]  flag_q, set_v, hclr_v;
  logic [STAT_W-1:0] stat_byte;
  logic [EN_W-1:0]   en_q;
  logic [DATA_W-1:0] rdr_q;

  assign stat_rd = bus_en_i & ~bus_we_i & (bus_addr_i == A_STAT);
  assign stat_wr = bus_en_i &  bus_we_i & (bus_addr_i == A_STAT);
  assign ctrl_wr = bus_en_i &  bus_we_i & (bus_addr_i == A_CTRL);
  assign rxd_rd  = bus_en_i & ~bus_we_i & (bus_addr_i == A_RXD);
  assign txd_wr  = bus_en_i &  bus_we_i & (bus_addr_i == A_TXD);

  // pending overrun freezes the port
  assign xfer_hold_o = flag_q[FL_ORER];
  assign rx_acc      = rx_done_i & ~flag_q[FL_ORER];
  assign rx_load     = rx_acc & ~flag_q[FL_RDRF];

  always_comb begin
    set_v  = '0;
    hclr_v = '0;
    set_v[FL_CE]    = conf_err_i;
    set_v[FL_RDRF]  = rx_load;
    set_v[FL_ORER]  = rx_acc & flag_q[FL_RDRF];
    set_v[FL_TDRE]  = tx_load_i & ~flag_q[FL_ORER];
    set_v[FL_TEND]  = tx_done_i & flag_q[FL_TDRE] & ~flag_q[FL_ORER];
    hclr_v[FL_RDRF] = rxd_rd;
    hclr_v[FL_TDRE] = txd_wr;
    hclr_v[FL_TEND] = txd_wr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ssf_flag #(.RST_VAL(g == FL_TDRE)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .hclr_i (hclr_v[g]),
      .rd_i   (stat_rd),
      .wr_i   (stat_wr),
      .wbit_i (bus_wdata_i[stat_pos(g)]),
      .q_o    (flag_q[g])
    );
  end

  always_comb begin
    stat_byte = '0;
    for (int i = 0; i < NFLAG; i++) stat_byte[stat_pos(i)] = flag_q[i];
  end

  ssf_data #(.DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_load_i (rx_load),
    .rx_byte_i (rx_byte_i),
    .tx_wr_i   (txd_wr),
    .wdata_i   (bus_wdata_i),
    .rdr_o     (rdr_q),
    .tdr_o     (tx_data_o)
  );

  ssf_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .wdata_i    (bus_wdata_i[EN_W-1:0]),
    .flag_i     (flag_q),
    .en_o       (en_q),
    .irq_tx_o   (irq_tx_o),
    .irq_rx_o   (irq_rx_o),
    .irq_ovr_o  (irq_ovr_o),
    .irq_conf_o (irq_conf_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      unique case (bus_addr_i)
        A_STAT:  bus_rdata_o = DATA_W'(stat_byte);
        A_CTRL:  bus_rdata_o = DATA_W'(en_q);
        A_RXD:   bus_rdata_o = rdr_q;
        default: bus_rdata_o = tx_data_o;
      endcase
    end
  end
endmodule

// File: rtl/ssf_status_chk.sv
module ssf_status_chk
  import ssf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic              rx_done_i,
  input logic              tx_load_i,
  input logic              tx_done_i,
  input logic              conf_err_i,
  input logic [NFLAG-1:0]  flag_q,
  input logic [DATA_W-1:0] rdr_q,
  input logic              xfer_hold_o,
  input logic              irq_rx_o,
  input logic              irq_ovr_o
);
  logic st_wr, rx_rd, no_evt;
  assign st_wr  = bus_en_i & bus_we_i & (bus_addr_i == A_STAT);
  assign rx_rd  = bus_en_i & ~bus_we_i & (bus_addr_i == A_RXD);
  assign no_evt = ~rx_done_i & ~tx_load_i & ~tx_done_i & ~conf_err_i;

  // R2
  rdrf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && !rx_done_i && flag_q[FL_RDRF]) |=> !flag_q[FL_RDRF]);

  // R3
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && flag_q[FL_RDRF] && !flag_q[FL_ORER])
      |=> (flag_q[FL_ORER] && $stable(rdr_q)));

  // R4
  ovr_rx_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FL_ORER] && rx_done_i) |=> $stable(rdr_q));

  // R4
  ovr_tx_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FL_ORER] && !flag_q[FL_TDRE] && tx_load_i) |=> !flag_q[FL_TDRE]);

  // R4
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovr_o |-> xfer_hold_o);

  // R6
  no_write_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && no_evt) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R10
  irq_rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |-> flag_q[FL_RDRF]);
endmodule

bind ssf_status_top ssf_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ssf_status_top_tb.sv
module ssf_status_top_tb_top;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0, rx_done = 0, tx_load = 0, tx_done = 0, conf_err = 0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, rx_byte = '0, bus_rdata, tx_data;
  logic hold, irq_tx, irq_rx, irq_ovr, irq_conf;
  logic [DW-1:0] rd_v;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ssf_status_top #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte), .tx_load_i(tx_load),
    .tx_done_i(tx_done), .conf_err_i(conf_err), .tx_data_o(tx_data),
    .xfer_hold_o(hold), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx),
    .irq_ovr_o(irq_ovr), .irq_conf_o(irq_conf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus/strobe cycle, applied at negedge, rdata captured before the edge
  task automatic cyc(input logic en, input logic we, input logic [1:0] a, input logic [DW-1:0] wd,
                     input logic rxd, input logic [DW-1:0] rxb, input logic txl,
                     input logic txd, input logic ce);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    rx_done = rxd; rx_byte = rxb; tx_load = txl; tx_done = txd; conf_err = ce;
    #1 rd_v = bus_rdata;
    @(negedge clk);
    bus_en = 0; bus_we = 0; rx_done = 0; tx_load = 0; tx_done = 0; conf_err = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a);        cyc(1, 0, a, '0, 0, '0, 0, 0, 0); endtask
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d); cyc(1, 1, a, d, 0, '0, 0, 0, 0); endtask
  task automatic rx(input logic [DW-1:0] b);     cyc(0, 0, 0, '0, 1, b, 0, 0, 0); endtask
  task automatic txl();                          cyc(0, 0, 0, '0, 0, '0, 1, 0, 0); endtask
  task automatic txd();                          cyc(0, 0, 0, '0, 0, '0, 0, 1, 0); endtask
  task automatic cfe();                          cyc(0, 0, 0, '0, 0, '0, 0, 0, 1); endtask
  task automatic clear_all();                    rd(2'd0); wr(2'd0, 8'h00); endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pos[5] = '{0, 1, 2, 3, 6};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq/hold", {hold, irq_tx, irq_rx, irq_ovr, irq_conf}, 0);
    rd(2'd0); check("R1 status", rd_v, 8'h04);
    rd(2'd1); check("R1 control", rd_v, 8'h00);

    // R5 sweep: unarmed write keeps flag, armed write clears
    for (int k = 0; k < 5; k++) begin
      logic [7:0] m;
      m = 8'(1 << pos[k]);
      case (k)
        0: cfe();
        1: rx(8'h10);
        2: begin wr(2'd3, 8'h01); txl(); end
        3: begin txl(); txd(); end
        default: begin rx(8'h20); rx(8'h21); end
      endcase
      wr(2'd0, ~m);
      rd(2'd0); check("R5 unarmed keep", rd_v & m, m);
      check("R1 reserved zero", rd_v & 8'hB0, 0);
      wr(2'd0, ~m);
      rd(2'd0); check("R5 armed clear", rd_v & m, 0);
    end

    // R6 writing ones never sets
    clear_all();
    wr(2'd0, 8'hFF);
    rd(2'd0); check("R6 ones", rd_v, 8'h00);

    // R9 / R5 arm consumed by any status write
    cfe();
    rd(2'd0); check("R9 conflict set", rd_v, 8'h01);
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h00);
    rd(2'd0); check("R5 arm consumed", rd_v, 8'h01);
    // R7 set wins: armed by the read above
    cyc(1, 1, 2'd0, 8'h00, 0, '0, 0, 0, 1);
    rd(2'd0); check("R7 set wins", rd_v, 8'h01);
    wr(2'd0, 8'h00);
    rd(2'd0); check("R7 clear after", rd_v, 8'h00);

    // R2 receive full
    rx(8'hC3);
    rd(2'd0); check("R2 rdrf set", rd_v, 8'h02);
    rd(2'd2); check("R2 rx data", rd_v, 8'hC3);
    rd(2'd0); check("R2 rdrf clr", rd_v, 8'h00);

    // R3 / R4 overrun
    wr(2'd1, 8'h02);
    wr(2'd3, 8'h11);
    rx(8'hA5); rx(8'h3C);
    check("R4 hold", hold, 1);
    check("R10 irq_ovr", irq_ovr, 1);
    rd(2'd0); check("R3 orer set", rd_v, 8'h42);
    rd(2'd2); check("R3 first byte kept", rd_v, 8'hA5);
    txl();
    rd(2'd0); check("R4 tx blocked", rd_v, 8'h40);
    rx(8'h77);
    rd(2'd0); check("R4 rx ignored flags", rd_v, 8'h40);
    rd(2'd2); check("R4 rx ignored data", rd_v, 8'hA5);
    rd(2'd0);
    wr(2'd0, 8'hBF);
    check("R4 hold released", hold, 0);
    rd(2'd0); check("R3 orer cleared", rd_v, 8'h00);
    rx(8'h77);
    rd(2'd2); check("R2 rx resumes", rd_v, 8'h77);

    // R8 transmit flags
    clear_all();
    wr(2'd3, 8'h5A);
    check("R8 tx data", tx_data, 8'h5A);
    txd();
    rd(2'd0); check("R8 tend needs tdre", rd_v, 8'h00);
    txl();
    rd(2'd0); check("R8 tdre set", rd_v, 8'h04);
    txd();
    rd(2'd0); check("R8 tend set", rd_v, 8'h0C);
    wr(2'd3, 8'h33);
    rd(2'd0); check("R8 tdr write clears", rd_v, 8'h00);

    // R10 enable sweep over two flag states
    for (int s = 0; s < 2; s++) begin
      clear_all();
      if (s == 1) begin txl(); cfe(); rx(8'h01); rx(8'h02); end
      for (int e = 0; e < 8; e++) begin
        logic f;
        f = (s == 1);
        wr(2'd1, 8'(e) | 8'hF8);
        rd(2'd1); check("R10 ctrl readback", rd_v, e);
        check("R10 irq_tx",   irq_tx,   e[2] & f);
        check("R10 irq_rx",   irq_rx,   e[1] & f);
        check("R10 irq_ovr",  irq_ovr,  e[1] & f);
        check("R10 irq_conf", irq_conf, e[0] & f);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule